// File: doc/BRIEF.md
# TDMA Memory-Phase Gate Scheduler

This controller sits beside a group of cores that share one main memory. Every task on a core runs as a memory phase followed by a computation phase. Each cycle, each core reports which of its tasks has a memory phase pending and which has a compute phase pending. Priority is the task index: index 0 is the most urgent. The controller then says which single task each core may run in that cycle, and whether that task runs its memory phase or its compute phase.

Memory is handed out in coarse time slots. A rotating slot sequencer makes one core at a time the slot owner. Each core's slot length is a programmable number of cycles. The TDMA period is the sum of all slot lengths, so a core's share of memory bandwidth is its slot length divided by that sum. Inside its own slot a core serves memory phases before compute phases. A memory phase that has started keeps memory until it finishes. When its slot runs out first, the phase is suspended and takes memory back at the start of that core's next slot. Outside its slot a core may only compute.

Each core has a phase state machine with three states:
- `PH_FREE`: no memory phase is started.
- `PH_MEM`: a started memory phase holds the current slot.
- `PH_HELD`: a started memory phase is waiting for the core's next slot.

The transitions are:
- FREE→MEM: a memory phase starts and the slot continues.
- FREE→HELD: a memory phase starts in the last cycle of the slot.
- FREE→FREE: no memory phase starts.
- MEM→MEM: the phase, or a newly picked one, keeps running inside the slot.
- MEM→HELD: the slot ends while the phase is unfinished.
- MEM→FREE: the phase finished and no other memory phase is pending in the slot.
- HELD→HELD: the core is still outside its slot.
- HELD→MEM: the core's slot comes back.
- HELD→FREE: the suspended task withdrew its request.

Top module: `tdma_gate_sched`

## Requirements
- R1: After reset core 0 owns the first slot. Ownership then passes in the order 0, 1, …, NCORES-1 and wraps. Core c owns `slot_len_i[c*LEN_W +: LEN_W]` consecutive cycles, so the period is the sum of all slot lengths.
- R2: A slot length of 0 is treated as a one-cycle slot.
- R3: A memory phase is granted only to the core shown on `slot_core_o`, and to at most one core in any cycle.
- R4: While a core owns the slot and any of its tasks has a memory phase pending, the core runs a memory phase, even if a compute phase of a more urgent task is pending.
- R5: Within one phase class on one core, the pending task with the lowest index is chosen.
- R6: Once a memory phase has been granted, it keeps the grant in every later cycle of the same slot while its request stays high, even if a lower-index memory request arrives.
- R7: A memory phase that is unfinished when the slot ends is suspended. In the first cycle of that core's next slot it is granted again, ahead of lower-index memory requests.
- R8: Outside its slot a core runs the lowest-index pending compute phase, or nothing. Its memory requests are not granted there.
- R9: A memory phase ends when its task lowers the request. The core then picks by R4/R5 in that same cycle.
- R10: `run_o` has at most one bit set per core. `run_mem_o[c]` is 1 exactly when core c's granted task runs its memory phase.
- R11: During and right after reset, `slot_core_o` is 0, no phase is suspended, and with no requests nothing runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slot_len_i | input | NCORES*LEN_W | Slot length per core, in cycles |
| mem_req_i | input | NCORES*NTASK | Pending memory phase, per core and task |
| cmp_req_i | input | NCORES*NTASK | Pending compute phase, per core and task |
| run_o | output | NCORES*NTASK | Task granted this cycle, per core |
| run_mem_o | output | NCORES | Granted task runs its memory phase |
| slot_core_o | output | OWN_W | Current slot owner |

## Verification
The bench targets these failure modes:
- A lower-index memory request arriving mid-phase. A preemptive design would switch tasks.
- A phase cut off at the slot edge while a more urgent request waits. A design that drops the lock would hand the next slot to the urgent task instead of resuming the suspended one.
- An urgent compute request inside the slot. A design that ranks by priority alone would let it run ahead of a memory phase.
- Memory requests outside the slot, which must never reach memory.
- Rotation under ordinary and zero slot lengths. An off-by-one counter would stretch or shorten every slot and skew the bandwidth share.

// File: rtl/tdma_gate_pkg.sv
package tdma_gate_pkg;
    typedef enum logic [1:0] {
        PH_FREE = 2'd0,
        PH_MEM  = 2'd1,
        PH_HELD = 2'd2
    } ph_state_e;
endpackage

// File: rtl/tdma_slot_seq.sv
module tdma_slot_seq #(
    parameter int NCORES = 4,
    parameter int LEN_W  = 12,
    localparam int OWN_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCORES*LEN_W-1:0] slot_len,
    output logic [OWN_W-1:0]        owner_q,
    output logic [OWN_W-1:0]        owner_d
);
    localparam logic [OWN_W-1:0] LAST_OWN = OWN_W'(NCORES - 1);

    logic [LEN_W-1:0] cnt_q, cnt_d, len_cur, len_eff, cnt_last;
    logic             slot_end;

    always_comb begin
        len_cur  = slot_len[owner_q*LEN_W +: LEN_W];
        len_eff  = (len_cur == '0) ? LEN_W'(1) : len_cur;
        cnt_last = len_eff - LEN_W'(1);
        slot_end = (cnt_q >= cnt_last);
        cnt_d    = slot_end ? '0 : cnt_q + LEN_W'(1);
        if (!slot_end)
            owner_d = owner_q;
        else if (owner_q == LAST_OWN)
            owner_d = '0;
        else
            owner_d = owner_q + OWN_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            owner_q <= '0;
        end else begin
            cnt_q   <= cnt_d;
            owner_q <= owner_d;
        end
    end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/core_phase_ctl.sv
module core_phase_ctl
    import tdma_gate_pkg::*;
#(
    parameter int NTASK = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_slot,
    input  logic             in_slot_nxt,
    input  logic [NTASK-1:0] mem_req,
    input  logic [NTASK-1:0] cmp_req,
    output logic [NTASK-1:0] run,
    output logic             run_mem
);
    ph_state_e        state_q, state_d;
    logic [NTASK-1:0] lock_q, lock_d;
    logic [NTASK-1:0] mem_oh, cmp_oh, mem_sel;
    logic             lock_live, mem_go;

    prio_pick #(.N(NTASK)) u_mem_pick (.req(mem_req), .gnt(mem_oh));
    prio_pick #(.N(NTASK)) u_cmp_pick (.req(cmp_req), .gnt(cmp_oh));

    // output process: which task runs this cycle
    always_comb begin
        lock_live = (state_q != PH_FREE) && ((mem_req & lock_q) != '0);
        mem_sel   = '0;
        if (in_slot && lock_live)
            mem_sel = lock_q;
        else if (in_slot)
            mem_sel = mem_oh;
        mem_go  = (mem_sel != '0);
        run     = mem_go ? mem_sel : cmp_oh;
        run_mem = mem_go;
    end

    // next-state process
    always_comb begin
        state_d = PH_FREE;
        lock_d  = '0;
        unique case (state_q)
            PH_FREE, PH_MEM: begin
                if (mem_go) begin
                    lock_d  = mem_sel;
                    state_d = in_slot_nxt ? PH_MEM : PH_HELD;
                end
            end
            PH_HELD: begin
                if (mem_go) begin
                    lock_d  = mem_sel;
                    state_d = in_slot_nxt ? PH_MEM : PH_HELD;
                end else if (lock_live) begin
                    lock_d  = lock_q;
                    state_d = in_slot_nxt ? PH_MEM : PH_HELD;
                end
            end
            default: begin
                state_d = PH_FREE;
                lock_d  = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_FREE;
            lock_q  <= '0;
        end else begin
            state_q <= state_d;
            lock_q  <= lock_d;
        end
    end
endmodule

// File: rtl/tdma_gate_sched.sv
module tdma_gate_sched #(
    parameter int NCORES = 4,
    parameter int NTASK  = 8,
    parameter int LEN_W  = 12,
    localparam int OWN_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCORES*LEN_W-1:0] slot_len_i,
    input  logic [NCORES*NTASK-1:0] mem_req_i,
    input  logic [NCORES*NTASK-1:0] cmp_req_i,
    output logic [NCORES*NTASK-1:0] run_o,
    output logic [NCORES-1:0]       run_mem_o,
    output logic [OWN_W-1:0]        slot_core_o
);
    logic [OWN_W-1:0]  owner_q, owner_d;
    logic [NCORES-1:0] in_slot, in_slot_nxt;

    tdma_slot_seq #(.NCORES(NCORES), .LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_len (slot_len_i),
        .owner_q  (owner_q),
        .owner_d  (owner_d)
    );

    assign slot_core_o = owner_q;

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        localparam logic [OWN_W-1:0] CID = OWN_W'(c);
        assign in_slot[c]     = (owner_q == CID);
        assign in_slot_nxt[c] = (owner_d == CID);

        core_phase_ctl #(.NTASK(NTASK)) u_core (
            .clk         (clk),
            .rst_n       (rst_n),
            .in_slot     (in_slot[c]),
            .in_slot_nxt (in_slot_nxt[c]),
            .mem_req     (mem_req_i[c*NTASK +: NTASK]),
            .cmp_req     (cmp_req_i[c*NTASK +: NTASK]),
            .run         (run_o[c*NTASK +: NTASK]),
            .run_mem     (run_mem_o[c])
        );
    end
endmodule

// File: rtl/tdma_gate_sched_chk.sv
module tdma_gate_sched_chk #(
    parameter int NCORES = 4,
    parameter int NTASK  = 8,
    parameter int OWN_W  = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NCORES*NTASK-1:0] mem_req,
    input logic [NCORES*NTASK-1:0] cmp_req,
    input logic [NCORES*NTASK-1:0] run,
    input logic [NCORES-1:0]       run_mem,
    input logic [OWN_W-1:0]        slot_core
);
    localparam logic [OWN_W-1:0] LAST_OWN = OWN_W'(NCORES - 1);

    // R1: owner stays or moves to the next core in order
    a_r1_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_core != $past(slot_core)) |->
        (slot_core == (($past(slot_core) == LAST_OWN) ? '0 : $past(slot_core) + OWN_W'(1))));

    // R3: at most one core touches memory
    a_r3_one_mem: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(run_mem) <= 1);

    for (genvar c = 0; c < NCORES; c++) begin : g_chk
        localparam logic [OWN_W-1:0] CID = OWN_W'(c);
        logic [NTASK-1:0] rc, mc, cc;
        assign rc = run[c*NTASK +: NTASK];
        assign mc = mem_req[c*NTASK +: NTASK];
        assign cc = cmp_req[c*NTASK +: NTASK];

        // R3: memory only for the slot owner
        a_r3_owner_only: assert property (@(posedge clk) disable iff (!rst_n)
            run_mem[c] |-> (slot_core == CID));

        // R10: one task per core
        a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(rc));

        // R4: pending memory phase in slot always wins
        a_r4_mem_first: assert property (@(posedge clk) disable iff (!rst_n)
            ((slot_core == CID) && (mc != '0)) |-> run_mem[c]);

        // R6: a started memory phase is not displaced within the slot
        a_r6_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
            run_mem[c] |=> ((slot_core != CID) || ((mc & $past(rc)) == '0) || (rc == $past(rc))));

        // R8: outside the slot a pending compute phase runs
        a_r8_compute_out: assert property (@(posedge clk) disable iff (!rst_n)
            ((slot_core != CID) && (cc != '0)) |-> ((rc != '0) && !run_mem[c]));
    end
endmodule

bind tdma_gate_sched tdma_gate_sched_chk #(
    .NCORES (NCORES),
    .NTASK  (NTASK),
    .OWN_W  (OWN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req_i),
    .cmp_req   (cmp_req_i),
    .run       (run_o),
    .run_mem   (run_mem_o),
    .slot_core (slot_core_o)
);

// File: tb/tb_tdma_gate_sched.sv
module tb_tdma_gate_sched;
    localparam int NC = 2;
    localparam int NT = 4;
    localparam int LW = 8;
    localparam int NV = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2*LW-1:0] slot_len = '0;
    logic [7:0]    mem_req = '0;
    logic [7:0]    cmp_req = '0;
    logic [7:0]    run;
    logic [1:0]    run_mem;
    logic          slot_core;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    tdma_gate_sched #(.NCORES(NC), .NTASK(NT), .LEN_W(LW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_len_i  (slot_len),
        .mem_req_i   (mem_req),
        .cmp_req_i   (cmp_req),
        .run_o       (run),
        .run_mem_o   (run_mem),
        .slot_core_o (slot_core)
    );

    // slot lengths 3 and 2; row i is applied in cycle i after reset release
    localparam logic [3:0] M0 [NV] = '{4'b0110, 4'b0111, 4'b0101, 4'b0101, 4'b0101,
                                       4'b0100, 4'b0100, 4'b0000, 4'b0000, 4'b1000, 4'b1000};
    localparam logic [3:0] C0 [NV] = '{4'b0001, 4'b0000, 4'b0000, 4'b1000, 4'b0000,
                                       4'b0000, 4'b0000, 4'b0011, 4'b0010, 4'b0000, 4'b0000};
    localparam logic [3:0] M1 [NV] = '{4'b0000, 4'b0000, 4'b0000, 4'b0010, 4'b0011,
                                       4'b0011, 4'b0011, 4'b0011, 4'b0011, 4'b0001, 4'b0001};
    localparam logic [3:0] C1 [NV] = '{4'b0100, 4'b0000, 4'b0010, 4'b0000, 4'b0000,
                                       4'b0100, 4'b0100, 4'b0100, 4'b0000, 4'b0000, 4'b0010};
    localparam logic [3:0] G0 [NV] = '{4'b0010, 4'b0010, 4'b0001, 4'b1000, 4'b0000,
                                       4'b0100, 4'b0100, 4'b0001, 4'b0010, 4'b0000, 4'b1000};
    localparam logic       P0 [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0,
                                       1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam logic [3:0] G1 [NV] = '{4'b0100, 4'b0000, 4'b0010, 4'b0010, 4'b0010,
                                       4'b0100, 4'b0100, 4'b0100, 4'b0010, 4'b0001, 4'b0010};
    localparam logic       P1 [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1,
                                       1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic       OW [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1,
                                       1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

    function automatic string vec_req(input int i);
        case (i)
            0:  return "R4";   // memory over urgent compute; R10 flag
            1:  return "R6";   // lower-index request arrives mid-phase
            2:  return "R9";   // phase done, next picked by R5
            3:  return "R8";   // out-of-slot compute; core1 starts memory (R3)
            4:  return "R6";   // core1 keeps task1 despite task0
            5:  return "R9";   // core0 suspended task withdrew, pick new
            6:  return "R5";
            7:  return "R4";   // no memory pending, compute in slot
            8:  return "R7";   // core1 resumes suspended task1 before task0
            9:  return "R8";   // core0 memory request outside slot ignored
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [LW-1:0] l0, input logic [LW-1:0] l1);
        rst_n    = 1'b0;
        slot_len = {l1, l0};
        mem_req  = '0;
        cmp_req  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        do_reset(8'd3, 8'd2);
        #5;
        chk("R11", "run in reset", int'(run), 0);
        chk("R11", "run_mem in reset", int'(run_mem), 0);
        chk("R11", "owner in reset", int'(slot_core), 0);

        // table walk
        do_reset(8'd3, 8'd2);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            mem_req = {M1[i], M0[i]};
            cmp_req = {C1[i], C0[i]};
            #5;
            chk(vec_req(i), $sformatf("vec %0d grant", i),
                int'({run[7:4], run_mem[1], run[3:0], run_mem[0]}),
                int'({G1[i], P1[i], G0[i], P0[i]}));
            chk("R1", $sformatf("vec %0d owner", i), int'(slot_core), int'(OW[i]));
            @(negedge clk);
        end

        // R1: rotation with lengths 3 and 2, share 3/5
        do_reset(8'd3, 8'd2);
        rst_n = 1'b1;
        begin
            int own0 = 0;
            for (int i = 0; i < 10; i++) begin
                #5;
                chk("R1", $sformatf("owner cycle %0d", i), int'(slot_core),
                    ((i % 5) < 3) ? 0 : 1);
                if (slot_core == 1'b0) own0++;
                @(negedge clk);
            end
            chk("R1", "core0 share of 10 cycles", own0, 6);
        end

        // R2: zero length acts as one cycle
        do_reset(8'd3, 8'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            #5;
            chk("R2", $sformatf("owner cycle %0d", i), int'(slot_core),
                ((i % 4) < 3) ? 0 : 1);
            @(negedge clk);
        end

        // R11: right after release no request runs nothing
        do_reset(8'd3, 8'd2);
        rst_n = 1'b1;
        #5;
        chk("R11", "idle after release", int'(run), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule